// File: doc/BRIEF.md
# Parallel EEPROM Page Programmer

This block is a clocked bus master that loads one page of a byte-wide parallel EEPROM and then waits for the internal programming cycle to finish. A single start request supplies a page number, a byte count from 1 to the page size, a mode bit and a flat data buffer. The block sends the bytes as consecutive write pulses, keeping every pulse on the same page and spacing the pulses well inside the memory's load window. It then polls the memory until programming is over.

Completion is found in one of two ways, chosen per request. In data-polling mode the block reads the last written location until the top data bit matches the top bit of the byte it wrote. In toggle mode it reads repeatedly and waits until bit 6 returns the same value on two reads in a row. A final full-byte read of the last location confirms the result. The request then ends with a single-cycle done pulse, with the error flag set if the confirmation differs, if polling ran past a time limit, or if the byte count was out of range.

Every setup, pulse, access and float time is a parameter in clock cycles, so one netlist can follow any clock rate.

Top module: `pgp_top`

## Requirements
- R1: While reset is held and afterwards until a start, the chip enable, output enable and write enable strobes are high (inactive), the data bus is released (`mem_dq_oe_o` low), and `done_o` and `err_o` are low.
- R2: Write enable is low only while chip enable is low, output enable is high and the data bus is driven, and it stays low for T_WP cycles. The data bus stays driven until after write enable has returned high.
- R3: Byte i of a request (buffer bits 8i+7 down to 8i, for i from 0 to count-1) is written to address {page, i}, with the page number in the upper ADDR_W-6 address bits and i in the low 6 bits for the default 64-byte page. Every write of a request uses the same page bits.
- R4: Successive write-enable falling edges within one request are fewer than BLC_CYC cycles apart.
- R5: In data-polling mode (`mode_i` = 0) polling reads use the last written address. Polling ends on the first read whose bit 7 equals bit 7 of the last written byte.
- R6: In toggle mode (`mode_i` = 1) polling ends on the first read whose bit 6 equals bit 6 of the read before it.
- R7: Output enable and the data-bus drive are never active together. Each read keeps output enable low for at least T_RD cycles before the data is taken. At least T_FLT cycles with all strobes inactive and the bus released come before each read and after it.
- R8: After polling ends, one more read of the last address is made. The request finishes with `err_o` = 0 if that byte equals the written byte, and with `err_o` = 1 otherwise.
- R9: If polling has not ended TIMEOUT_CYC cycles after the last write, the request finishes with `err_o` = 1 and all strobes inactive.
- R10: `done_o` is high for exactly one cycle per request, and `err_o` is high only in a cycle where `done_o` is high.
- R11: A start with a count of 0 or larger than PAGE_BYTES produces `done_o` with `err_o` = 1 in the next cycle, with no bus cycle.
- R12: A start that arrives while a request is in progress is ignored. It causes no write and no extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to program a page |
| mode_i | input | 1 | Completion method: 0 data polling, 1 toggle bit |
| page_i | input | ADDR_W-COL_W (9) | Page number for the request |
| count_i | input | CNT_W (7) | Number of bytes, 1 to PAGE_BYTES |
| wdata_i | input | PAGE_BYTES*8 (512) | Byte buffer; held stable while the request runs |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 1 | Failure flag, valid with done_o |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_addr_o | output | ADDR_W (15) | Memory address |
| mem_dq_o | output | 8 | Data bus, outgoing value |
| mem_dq_oe_o | output | 1 | Drive enable for the data bus pad |
| mem_dq_i | input | 8 | Data bus, incoming value |

## Verification
A wrong sequencer state shows at the memory pins within a cycle: write enable low without chip enable, a bus still driven while output enable falls, or an address whose page bits move in the middle of a burst. A broken completion rule shows later, at the end of the request. Stopping early makes the confirming read return busy data, and an error is flagged even though the memory finished correctly. Stopping too late shows only as extra polling reads, so the bench checks each read's address and how long each read lasts. A counter that is not cleared shows one request later, as a lost or doubled done pulse or as bytes landing at the wrong offsets of a page.

// File: rtl/pgp_pkg.sv
package pgp_pkg;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_WSET,
      PS_WPUL,
      PS_WHLD,
      PS_RGAP,
      PS_RACC,
      PS_FIN
   } pgp_state_e;

   localparam logic MODE_TOGGLE = 1'b1;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pgp_timer.sv
module pgp_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pgp_judge.sv
module pgp_judge (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear_i,
   input  logic       sample_i,
   input  logic       toggle_i,
   input  logic [7:0] rd_i,
   input  logic       want7_i,
   output logic       complete_o
);

   logic prev6_q;
   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev6_q <= 1'b0;
         seen_q  <= 1'b0;
      end else if (clear_i) begin
         seen_q  <= 1'b0;
      end else if (sample_i) begin
         prev6_q <= rd_i[6];
         seen_q  <= 1'b1;
      end
   end

   always_comb begin
      if (toggle_i) begin
         complete_o = sample_i && seen_q && (rd_i[6] == prev6_q);
      end else begin
         complete_o = sample_i && (rd_i[7] == want7_i);
      end
   end

endmodule

// File: rtl/pgp_top.sv
module pgp_top
   import pgp_pkg::*;
#(
   parameter int ADDR_W      = 15,
   parameter int PAGE_BYTES  = 64,
   parameter int T_SETUP     = 2,
   parameter int T_WP        = 20,
   parameter int T_HOLD      = 2,
   parameter int T_RD        = 41,
   parameter int T_FLT       = 12,
   parameter int BLC_CYC     = 30000,
   parameter int TIMEOUT_CYC = 2100000,
   localparam int COL_W      = $clog2(PAGE_BYTES),
   localparam int PAGE_W     = ADDR_W - COL_W,
   localparam int CNT_W      = $clog2(PAGE_BYTES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic                    mode_i,
   input  logic [PAGE_W-1:0]       page_i,
   input  logic [CNT_W-1:0]        count_i,
   input  logic [PAGE_BYTES*8-1:0] wdata_i,
   output logic                    done_o,
   output logic                    err_o,
   output logic                    mem_ce_n_o,
   output logic                    mem_oe_n_o,
   output logic                    mem_we_n_o,
   output logic [ADDR_W-1:0]       mem_addr_o,
   output logic [7:0]              mem_dq_o,
   output logic                    mem_dq_oe_o,
   input  logic [7:0]              mem_dq_i
);

   localparam int T_MAX = imax(imax(imax(T_SETUP, T_WP), imax(T_HOLD, T_RD)), T_FLT);
   localparam int PH_W  = $clog2(T_MAX + 1);
   localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);

   localparam logic [PH_W-1:0] SET_V = PH_W'(T_SETUP - 1);
   localparam logic [PH_W-1:0] WP_V  = PH_W'(T_WP - 1);
   localparam logic [PH_W-1:0] HLD_V = PH_W'(T_HOLD - 1);
   localparam logic [PH_W-1:0] RD_V  = PH_W'(T_RD - 1);
   localparam logic [PH_W-1:0] FLT_V = PH_W'(T_FLT - 1);
   localparam logic [TO_W-1:0] TO_V  = TO_W'(TIMEOUT_CYC - 1);

   // elaboration-time parameter checks
   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("pgp_top: PAGE_BYTES must be a power of two of at least 2");
   end
   if (COL_W >= ADDR_W) begin : g_bad_addr
      $error("pgp_top: ADDR_W must exceed the page offset width");
   end
   if (T_SETUP < 1 || T_WP < 1 || T_HOLD < 1 || T_RD < 1 || T_FLT < 1) begin : g_bad_time
      $error("pgp_top: every phase length must be at least one cycle");
   end
   if (T_SETUP + T_WP + T_HOLD >= BLC_CYC) begin : g_bad_window
      $error("pgp_top: one byte slot does not fit the inter-byte window");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_to
      $error("pgp_top: TIMEOUT_CYC too small");
   end

   pgp_state_e        st_q, st_d;
   logic [PAGE_W-1:0] page_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  idx_q;
   logic              toggle_q;
   logic              verify_q;
   logic              mism_q;
   logic [7:0]        last_q;
   logic              done_q, err_q;

   logic              ph_load, ph_zero, to_load, to_zero;
   logic [PH_W-1:0]   ph_val;
   logic              j_clr, j_smp, j_done;
   logic              accept, bad_req, step, go_verify, cap_read, finish, fin_err;
   logic              cnt_ok, last_byte;
   logic [7:0]        wbyte;

   assign cnt_ok    = (count_i != '0) && (count_i <= CNT_W'(PAGE_BYTES));
   assign last_byte = (idx_q == cnt_q - 1'b1);
   assign wbyte     = wdata_i[{idx_q[COL_W-1:0], 3'b000} +: 8];

   pgp_timer #(.W(PH_W)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (ph_load),
      .val_i  (ph_val),
      .zero_o (ph_zero)
   );

   pgp_timer #(.W(TO_W)) u_limit (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (to_load),
      .val_i  (TO_V),
      .zero_o (to_zero)
   );

   pgp_judge u_judge (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (j_clr),
      .sample_i   (j_smp),
      .toggle_i   (toggle_q == MODE_TOGGLE),
      .rd_i       (mem_dq_i),
      .want7_i    (last_q[7]),
      .complete_o (j_done)
   );

   always_comb begin
      st_d      = st_q;
      ph_load   = 1'b0;
      ph_val    = '0;
      to_load   = 1'b0;
      j_clr     = 1'b0;
      j_smp     = 1'b0;
      accept    = 1'b0;
      bad_req   = 1'b0;
      step      = 1'b0;
      go_verify = 1'b0;
      cap_read  = 1'b0;
      finish    = 1'b0;
      fin_err   = 1'b0;
      unique case (st_q)
         PS_IDLE: begin
            if (start_i) begin
               if (cnt_ok) begin
                  accept  = 1'b1;
                  st_d    = PS_WSET;
                  ph_load = 1'b1;
                  ph_val  = SET_V;
               end else begin
                  bad_req = 1'b1;
               end
            end
         end
         PS_WSET: begin
            if (ph_zero) begin
               st_d    = PS_WPUL;
               ph_load = 1'b1;
               ph_val  = WP_V;
            end
         end
         PS_WPUL: begin
            if (ph_zero) begin
               st_d    = PS_WHLD;
               ph_load = 1'b1;
               ph_val  = HLD_V;
            end
         end
         PS_WHLD: begin
            if (ph_zero) begin
               ph_load = 1'b1;
               if (last_byte) begin
                  st_d    = PS_RGAP;
                  ph_val  = FLT_V;
                  to_load = 1'b1;
                  j_clr   = 1'b1;
               end else begin
                  step   = 1'b1;
                  st_d   = PS_WSET;
                  ph_val = SET_V;
               end
            end
         end
         PS_RGAP: begin
            if (!verify_q && to_zero) begin
               st_d    = PS_IDLE;
               finish  = 1'b1;
               fin_err = 1'b1;
            end else if (ph_zero) begin
               st_d    = PS_RACC;
               ph_load = 1'b1;
               ph_val  = RD_V;
            end
         end
         PS_RACC: begin
            if (ph_zero) begin
               ph_load = 1'b1;
               ph_val  = FLT_V;
               if (verify_q) begin
                  cap_read = 1'b1;
                  st_d     = PS_FIN;
               end else begin
                  j_smp     = 1'b1;
                  go_verify = j_done;
                  st_d      = PS_RGAP;
               end
            end
         end
         PS_FIN: begin
            if (ph_zero) begin
               st_d    = PS_IDLE;
               finish  = 1'b1;
               fin_err = mism_q;
            end
         end
         default: st_d = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= PS_IDLE;
         page_q   <= '0;
         cnt_q    <= '0;
         idx_q    <= '0;
         toggle_q <= 1'b0;
         verify_q <= 1'b0;
         mism_q   <= 1'b0;
         last_q   <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= bad_req | finish;
         err_q  <= bad_req | (finish & fin_err);
         if (accept) begin
            page_q   <= page_i;
            cnt_q    <= count_i;
            toggle_q <= mode_i;
            idx_q    <= '0;
            verify_q <= 1'b0;
            mism_q   <= 1'b0;
         end
         if (step) begin
            idx_q <= idx_q + 1'b1;
         end
         if (to_load) begin
            last_q <= wbyte;
         end
         if (go_verify) begin
            verify_q <= 1'b1;
         end
         if (cap_read) begin
            mism_q <= (mem_dq_i != last_q);
         end
      end
   end

   assign mem_ce_n_o  = !(st_q inside {PS_WSET, PS_WPUL, PS_WHLD, PS_RACC});
   assign mem_oe_n_o  = (st_q != PS_RACC);
   assign mem_we_n_o  = (st_q != PS_WPUL);
   assign mem_dq_oe_o = (st_q inside {PS_WSET, PS_WPUL, PS_WHLD});
   assign mem_dq_o    = wbyte;
   assign mem_addr_o  = {page_q, idx_q[COL_W-1:0]};
   assign done_o      = done_q;
   assign err_o       = err_q;

endmodule

// File: rtl/pgp_chk.sv
module pgp_chk #(
   parameter int ADDR_W  = 15,
   parameter int COL_W   = 6,
   parameter int BLC_CYC = 30000,
   parameter int T_RD    = 41
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              we_n,
   input logic              dq_oe,
   input logic              done,
   input logic              err,
   input logic [ADDR_W-1:0] addr
);

   localparam int GW = $clog2(BLC_CYC + 1);
   localparam int RW = $clog2(T_RD + 1);

   logic          we_d;
   logic          we_fall;
   logic          armed_q;
   logic [GW-1:0] gap_q;
   logic [RW-1:0] rd_q;

   assign we_fall = we_d && !we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_d    <= 1'b1;
         armed_q <= 1'b0;
         gap_q   <= '0;
         rd_q    <= '0;
      end else begin
         we_d    <= we_n;
         armed_q <= dq_oe ? (armed_q | we_fall) : 1'b0;
         if (we_fall) begin
            gap_q <= '0;
         end else if (gap_q != GW'(BLC_CYC)) begin
            gap_q <= gap_q + 1'b1;
         end
         if (oe_n) begin
            rd_q <= '0;
         end else if (rd_q != RW'(T_RD)) begin
            rd_q <= rd_q + 1'b1;
         end
      end
   end

   p_we_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (!ce_n && oe_n && dq_oe));

   p_drive_past_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dq_oe) |-> (we_n && $past(we_n)));

   p_one_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && $past(dq_oe)) |-> (addr[ADDR_W-1:COL_W] == $past(addr[ADDR_W-1:COL_W])));

   p_byte_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we_fall && armed_q) |-> (int'(gap_q) < BLC_CYC - 1));

   p_no_fight_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !dq_oe);

   p_read_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_n) |-> (int'(rd_q) >= T_RD));

   p_quiet_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ce_n && oe_n && we_n && !dq_oe));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

endmodule

bind pgp_top pgp_chk #(
   .ADDR_W  (ADDR_W),
   .COL_W   (COL_W),
   .BLC_CYC (BLC_CYC),
   .T_RD    (T_RD)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .ce_n  (mem_ce_n_o),
   .oe_n  (mem_oe_n_o),
   .we_n  (mem_we_n_o),
   .dq_oe (mem_dq_oe_o),
   .done  (done_o),
   .err   (err_o),
   .addr  (mem_addr_o)
);

// File: tb/tb_pgp_top.sv
`timescale 1ns/1ps
module tb_pgp_top;

   localparam int ADDR_W  = 15;
   localparam int PB      = 64;
   localparam int T_RD    = 41;
   localparam int T_FLT   = 12;
   localparam int BLC     = 30000;
   localparam int TMO     = 5000;
   localparam int BUSY    = 1500;
   localparam int RD_LAT  = 40;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              mode = 1'b0;
   logic [8:0]        page = '0;
   logic [6:0]        count = '0;
   logic [PB*8-1:0]   wbuf = '0;
   logic              done, err;
   logic              ce_n, oe_n, we_n, dq_oe;
   logic [ADDR_W-1:0] addr;
   logic [7:0]        dq_o;
   logic [7:0]        dq_i = 8'h00;

   always #2.5 clk = ~clk;

   pgp_top #(.TIMEOUT_CYC(TMO)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .mode_i      (mode),
      .page_i      (page),
      .count_i     (count),
      .wdata_i     (wbuf),
      .done_o      (done),
      .err_o       (err),
      .mem_ce_n_o  (ce_n),
      .mem_oe_n_o  (oe_n),
      .mem_we_n_o  (we_n),
      .mem_addr_o  (addr),
      .mem_dq_o    (dq_o),
      .mem_dq_oe_o (dq_oe),
      .mem_dq_i    (dq_i)
   );

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [7:0] mem  [int];
   logic [7:0] pbuf [int];
   bit         busy = 0;
   int         busy_left = 0;
   bit         stuck = 0;
   bit         corrupt = 0;
   bit         tog = 0;
   int         last_a = 0;
   logic [7:0] last_d = 8'h00;
   int         cur_a = 0;
   bit         we_p = 1, oe_p = 1;
   int         rd_cyc = 0;
   logic [7:0] rv = 8'h00;
   int         gap = 0;
   bit         in_burst = 0;
   int         burst_page = 0;
   int         flt_cnt = 0;

   function automatic logic [7:0] rd_mem(input int a);
      return mem.exists(a) ? mem[a] : 8'hFF;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         gap++;
         if (!dq_oe) in_burst = 0;
         if (we_p && !we_n) begin
            cur_a = int'(addr);
            if (in_burst) begin
               chk(int'(addr[14:6]) == burst_page, "R3 page bits within burst", int'(addr[14:6]), burst_page);
               chk(gap < BLC, "R4 write spacing", gap, BLC);
            end
            in_burst = 1;
            burst_page = int'(addr[14:6]);
            gap = 0;
         end
         if (!we_p && we_n) begin
            chk(dq_oe == 1'b1, "R2 bus driven at write rise", int'(dq_oe), 1);
            pbuf[cur_a] = dq_o;
            last_a = cur_a;
            last_d = dq_o;
            busy = 1;
            busy_left = BUSY;
         end
         if (busy && !stuck) begin
            busy_left--;
            if (busy_left <= 0) begin
               foreach (pbuf[k]) mem[k] = corrupt ? (pbuf[k] ^ 8'h01) : pbuf[k];
               pbuf.delete();
               busy = 0;
            end
         end
         if (!ce_n && !oe_n) begin
            rd_cyc++;
            if (rd_cyc == 1) begin
               chk(flt_cnt >= T_FLT, "R7 float before read", flt_cnt, T_FLT);
               chk(int'(addr) == last_a, "R5 poll address", int'(addr), last_a);
               if (busy) begin
                  rv = {~last_d[7], tog, 6'h15};
                  tog = ~tog;
               end else begin
                  rv = rd_mem(int'(addr));
               end
            end
            dq_i = (rd_cyc >= RD_LAT) ? rv : ~rv;
         end else begin
            rd_cyc = 0;
            dq_i = 8'h00;
         end
         if (ce_n && oe_n && we_n && !dq_oe) flt_cnt++;
         else if (!oe_n) flt_cnt = flt_cnt;
         else flt_cnt = 0;
         if (oe_p && !oe_n) flt_cnt = 0;
         we_p = we_n;
         oe_p = oe_n;
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      bit    err;
      int    page;
      int    cnt;
      string tag;
   } exp_t;

   exp_t       sb[$];
   int         ndone = 0;
   bit         done_p = 0;
   logic [PB*8-1:0] sb_data[$];

   always @(negedge clk) begin
      if (rst_n) begin
         if (err && !done) chk(0, "R10 err without done", 1, 0);
         if (done && done_p) chk(0, "R10 done longer than one cycle", 2, 1);
         if (done) begin
            ndone++;
            if (sb.size() == 0) begin
               chk(0, "R12 unexpected done", 1, 0);
            end else begin
               exp_t e;
               logic [PB*8-1:0] d;
               e = sb.pop_front();
               d = sb_data.pop_front();
               chk(err == e.err, e.tag, int'(err), int'(e.err));
               if (!e.err) begin
                  for (int i = 0; i < e.cnt; i++) begin
                     chk(rd_mem(e.page * PB + i) == d[i*8 +: 8], "R3 stored byte",
                         int'(rd_mem(e.page * PB + i)), int'(d[i*8 +: 8]));
                  end
               end
            end
         end
         done_p = done;
      end
   end

   // ---------------- driver ----------------
   task automatic fill(input int seed);
      for (int i = 0; i < PB; i++) wbuf[i*8 +: 8] = 8'((i * 37 + seed) & 8'hFF);
   endtask

   task automatic wait_done(input int target);
      while (ndone < target) @(negedge clk);
   endtask

   task automatic run_op(input int pg, input int cn, input bit md, input int seed,
                         input bit e_err, input string tag, input bit poke);
      exp_t e;
      int   target;
      fill(seed);
      page  = 9'(pg);
      count = 7'(cn);
      mode  = md;
      e.err = e_err; e.page = pg; e.cnt = cn; e.tag = tag;
      sb.push_back(e);
      sb_data.push_back(wbuf);
      target = ndone + 1;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      if (poke) begin
         repeat (100) @(negedge clk);
         page  = 9'd7;
         count = 7'd2;
         start = 1'b1;
         @(negedge clk) start = 1'b0;
      end
      wait_done(target);
      repeat (20) @(negedge clk);
   endtask

   task automatic bad_count(input int cn);
      int target;
      target = ndone + 1;
      begin
         exp_t e;
         e.err = 1; e.page = 0; e.cnt = cn; e.tag = "R11 count out of range";
         sb.push_back(e);
         sb_data.push_back(wbuf);
      end
      count = 7'(cn);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(done == 1'b1, "R11 done next cycle", int'(done), 1);
      for (int k = 0; k < 3; k++) begin
         chk(ce_n == 1'b1, "R11 no bus cycle", int'(ce_n), 1);
         @(negedge clk);
      end
      wait_done(target);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(ce_n && oe_n && we_n, "R1 strobes in reset", int'({ce_n, oe_n, we_n}), 7);
      chk(dq_oe == 1'b0, "R1 bus released in reset", int'(dq_oe), 0);
      chk(done == 1'b0 && err == 1'b0, "R1 outputs low in reset", int'({done, err}), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(ce_n && oe_n && we_n && !dq_oe, "R1 idle after reset", int'({ce_n, oe_n, we_n, dq_oe}), 14);

      // full page, data polling, with an ignored start in the middle
      run_op(5, 64, 1'b0, 3, 1'b0, "R5 R8 data polling full page", 1'b1);
      chk(!mem.exists(7 * PB) && !mem.exists(7 * PB + 1), "R12 ignored start wrote nothing", 0, 0);
      // single byte at top page, toggle mode
      run_op(511, 1, 1'b1, 200, 1'b0, "R6 R8 toggle single byte", 1'b0);
      // partial page, toggle mode
      run_op(12, 17, 1'b1, 91, 1'b0, "R6 toggle partial page", 1'b0);
      // verification mismatch
      corrupt = 1;
      run_op(20, 3, 1'b0, 150, 1'b1, "R8 verify mismatch", 1'b0);
      repeat (BUSY) @(negedge clk);
      corrupt = 0;
      // programming never finishes
      stuck = 1;
      run_op(9, 2, 1'b0, 77, 1'b1, "R9 timeout", 1'b0);
      stuck = 0;
      repeat (BUSY + 200) @(negedge clk);
      // out-of-range counts
      bad_count(0);
      bad_count(65);
      // normal request after errors still works
      run_op(33, 8, 1'b0, 5, 1'b0, "R8 recovery after errors", 1'b0);
      chk(sb.size() == 0, "R10 one done per request", sb.size(), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule